// File: doc/BRIEF.md
# Lockable Non-Maskable Interrupt Pin Monitor

This block sits between one asynchronous external pin and the interrupt logic of a processor. It brings the pin into the clock domain through a short flop chain. When software has armed it, every high-to-low transition of the pin produces a one-cycle non-maskable request. No interrupt-enable flag or priority level can block that request. Before arming, the pin is an ordinary general-purpose input. Its synchronized level can always be read at bit 5 of a port read-back byte.

Arming is done through a mode-register write port. Setting bit 4 of the written byte with the strobe high arms the block. The arm bit is sticky, and only reset clears it. Writes that clear bit 4 are ignored. Once armed, the pin is a permanent non-maskable source until the next reset. All control and status pins are plain signals with no handshake. Each strobe is one write, and the block never stalls the writer.

Top module: `nmi_pin_lock`

## Requirements
- R1: While reset is low and after it is released, the armed status `nmi_armed` is 0 and `nmi_req` is 0.
- R2: `nmi_req` is raised only for a high-to-low change of the synchronized pin. A rising edge or a steady low level raises no request.
- R3: Each qualifying falling edge gives `nmi_req` high for exactly one clock cycle.
- R4: A clock edge with `mode_wr` high and `mode_wdata[4]` = 1 sets `nmi_armed` from the next cycle. The other bits of `mode_wdata` have no effect on it.
- R5: Once `nmi_armed` is 1, writes with `mode_wdata[4]` = 0 leave it at 1. Only `rst_n` low returns it to 0.
- R6: `port_rd[5]` shows the synchronized pin level whether or not the block is armed, and all other bits of `port_rd` read 0.
- R7: A pin level change reaches `port_rd[5]` on the second rising clock edge after it is applied. A falling edge raises `nmi_req` in that same cycle.
- R8: While `nmi_armed` is 0, no falling edge raises `nmi_req`. A fall that happened while unarmed is not replayed when the block is armed later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_async | input | 1 | External pin, asynchronous, idles high |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data; bit 4 arms the block |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| port_rd | output | 8 | Port read-back; bit 5 is the synchronized pin level |
| nmi_armed | output | 1 | Arm status |

## Verification
The bench makes the pin fall while the block is unarmed and then arms it with the pin still low. A design that remembered the edge would fire a late request. It holds the pin low for many cycles and pulses it low for a single cycle. A level-sensitive or stretched request would show up as a multi-cycle pulse, and a missed request would show up as no pulse. It also writes bytes with every bit except bit 4 set, and it writes zero after arming. A design that decoded the wrong bit, or that let a write clear the arm bit, would show the wrong status. A mid-run reset then confirms that only reset disarms.

// File: rtl/nmi_pin_pkg.sv
package nmi_pin_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned ARM_BIT   = 4;
  localparam int unsigned LEVEL_BIT = 5;
  localparam int unsigned SYNC_LEN  = 2;
endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= IDLE_VAL;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= IDLE_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
        // R7
        sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
          1'b1 |=> chain_q[g] == $past(chain_q[g-1]));
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_arm_reg.sv
module nmi_arm_reg #(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned ARM_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             armed
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   armed_q <= 1'b0;
    else if (wr && wdata[ARM_BIT]) armed_q <= 1'b1;
  end

  assign armed = armed_q;

  // R5
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  // R4
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[ARM_BIT]) |=> armed_q);
endmodule

// File: rtl/nmi_fall_detect.sv
module nmi_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic armed,
  output logic req
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level;
  end

  assign req = armed && prev_q && !level;

  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
endmodule

// File: rtl/nmi_pin_lock.sv
module nmi_pin_lock
  import nmi_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_async,
  input  logic             mode_wr,
  input  logic [REG_W-1:0] mode_wdata,
  output logic             nmi_req,
  output logic [REG_W-1:0] port_rd,
  output logic             nmi_armed
);
  logic pin_lvl;
  logic armed;

  nmi_pin_sync #(.STAGES(SYNC_LEN), .IDLE_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_async), .d_sync(pin_lvl)
  );

  nmi_arm_reg #(.REG_W(REG_W), .ARM_BIT(ARM_BIT)) u_arm (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wdata(mode_wdata), .armed(armed)
  );

  nmi_fall_detect u_fall (
    .clk(clk), .rst_n(rst_n), .level(pin_lvl), .armed(armed), .req(nmi_req)
  );

  always_comb begin
    port_rd            = '0;
    port_rd[LEVEL_BIT] = pin_lvl;
  end

  assign nmi_armed = armed;

  // R8
  req_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> nmi_armed);
  // R2
  req_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> !port_rd[LEVEL_BIT]);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!nmi_armed && !nmi_req));
endmodule

// File: tb/nmi_pin_lock_bench.sv
module nmi_pin_lock_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_async = 1'b1;
  logic       mode_wr = 1'b0;
  logic [7:0] mode_wdata = 8'h00;
  logic       nmi_req;
  logic [7:0] port_rd;
  logic       nmi_armed;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nmi_pin_lock u_nmi_pin_lock (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .nmi_req(nmi_req), .port_rd(port_rd),
    .nmi_armed(nmi_armed)
  );

  // reference model: history of pin samples, newest first
  logic hist[$] = '{1'b1, 1'b1, 1'b1};
  bit   arm_m   = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit exp_req;
    if (!rst_n) begin
      hist  = '{1'b1, 1'b1, 1'b1};
      arm_m = 1'b0;
    end else begin
      hist.push_front(pin_async);
      void'(hist.pop_back());
      if (mode_wr && mode_wdata[4]) arm_m = 1'b1;
    end
    exp_req = arm_m && hist[2] && !hist[1];
    #2;
    if (nmi_req) pulses++;
    // R1 R4 R5 status; R6 R7 level and other bits; R2 R3 R8 request
    check(nmi_armed == arm_m, "R4/R5 arm status", nmi_armed, arm_m);
    check(port_rd == (8'(hist[1]) << 5), "R6/R7 port read-back", port_rd, 8'(hist[1]) << 5);
    check(nmi_req == exp_req, "R2/R3/R8 request", nmi_req, exp_req);
  end

  task automatic set_pin(input logic v, input int hold);
    @(negedge clk); pin_async = v;
    repeat (hold) @(negedge clk);
  endtask

  task automatic write_mode(input logic [7:0] v);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk); mode_wr = 1'b0; mode_wdata = 8'h00;
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(nmi_armed == 1'b0 && nmi_req == 1'b0, "R1 reset", nmi_armed, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8: falls while unarmed give nothing
    p0 = pulses;
    set_pin(1'b0, 4); set_pin(1'b1, 4); set_pin(1'b0, 1); set_pin(1'b1, 3);
    check(pulses == p0, "R8 unarmed falls", pulses - p0, 0);
    // R4: every bit except bit 4 does not arm
    write_mode(8'hEF);
    check(nmi_armed == 1'b0, "R4 other bits", nmi_armed, 0);
    // R8: fall while unarmed, then arm with pin still low: no late request
    p0 = pulses;
    set_pin(1'b0, 4);
    write_mode(8'h10);
    repeat (4) @(negedge clk);
    check(pulses == p0 && nmi_armed, "R8 not replayed", pulses - p0, 0);
    // R6: pin readable while armed
    check(port_rd == 8'h00, "R6 low level armed", port_rd, 0);
    set_pin(1'b1, 4);
    check(port_rd == 8'h20, "R6 high level armed", port_rd, 8'h20);
    // R3: long low gives one pulse
    p0 = pulses;
    set_pin(1'b0, 10);
    check(pulses - p0 == 1, "R3 long low one pulse", pulses - p0, 1);
    // R2: rising edge gives none
    p0 = pulses;
    set_pin(1'b1, 6);
    check(pulses == p0, "R2 rising edge", pulses - p0, 0);
    // R5: writing zero keeps arm
    write_mode(8'h00);
    write_mode(8'hEF);
    check(nmi_armed == 1'b1, "R5 sticky", nmi_armed, 1);
    // R3: short pulses, one request each
    p0 = pulses;
    for (int i = 0; i < 5; i++) begin set_pin(1'b0, 1); set_pin(1'b1, 1); end
    repeat (4) @(negedge clk);
    check(pulses - p0 == 5, "R3 short pulses", pulses - p0, 5);
    // R1 R5: only reset disarms
    @(negedge clk); rst_n = 1'b0; pin_async = 1'b0;
    repeat (2) @(negedge clk);
    check(nmi_armed == 1'b0 && nmi_req == 1'b0, "R1 mid reset", nmi_armed, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(nmi_armed == 1'b0, "R5 reset clears", nmi_armed, 0);
    set_pin(1'b1, 4);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); check(1'b0, "watchdog", 0, 1); end
    join_any
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule